// File: doc/BRIEF.md
# Multichannel ADC Readout Sequencer

This block drives a sampling converter that has its own result memory and a shared 16-bit bidirectional data bus. After reset it writes a 4-bit mode word to the converter once. It then releases the bus for good and settles into a fixed loop. Each pass pulses convert-start, waits for the converter's end-of-conversion interrupt, and reads four stored channel results in turn. Each result is trimmed to its valid bits and handed to a byte-wide transmit port as two bytes.

The downstream serial link is slow. A programmable idle gap therefore follows every byte handoff. A programmable period counter spaces successive conversions. The defaults assume a 10 MHz clock, a 10 ms gap and a 1 s period. The interrupt may be very short, so it is synchronised and edge-latched rather than sampled as a level.

Top module: `adc_readout_seq`

## Requirements
- R1: After reset the bus output enable is high and the bus carries the mode word 0x0003 (bits 3..0 = 0011, all higher bits zero). The write strobe goes low exactly once, for STROBE_CYC cycles, while the word is driven. In reset all strobes are high and tx_valid is low.
- R2: Once the mode word is written, bus_oe stays low and wr_n stays high for the rest of operation.
- R3: Convert-start is an active-low pulse of exactly STROBE_CYC cycles. It never overlaps a read strobe.
- R4: No read strobe is issued after a convert-start until a falling edge of int_n has been seen. An int_n low pulse of a single clock cycle is enough.
- R5: Each conversion is followed by four reads. Each read holds rd_n low for exactly STROBE_CYC cycles, and the bus is sampled on the last low cycle. Successive reads take successive stored results.
- R6: Result bits above VALID_W-1 are forced to zero. With VALID_W = 14, bits 7..6 of every high byte are zero.
- R7: Each result is sent high byte (bits 15..8) first, then low byte (bits 7..0), so one conversion yields eight bytes. While tx_valid is high and tx_ready is low, tx_valid and tx_data hold steady.
- R8: After every accepted byte, tx_valid stays low for at least GAP_CYC cycles before the next byte is offered.
- R9: Successive convert-start falling edges are exactly PERIOD_CYC cycles apart, as long as the eight bytes drain within the period. The first conversion follows the configuration write directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Data bus as read from the pins |
| bus_out | output | 16 | Data driven onto the bus pins when enabled |
| bus_oe | output | 1 | High while the block drives the bus |
| wr_n | output | 1 | Active-low write strobe for the mode word |
| rd_n | output | 1 | Active-low read strobe for stored results |
| convst_n | output | 1 | Active-low convert-start pulse |
| int_n | input | 1 | Active-low end-of-conversion interrupt, asynchronous |
| tx_data | output | 8 | Byte offered to the serial transmitter |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The hardest situation to reach from the ports combines several stresses on the same pass: an interrupt pulse only one clock wide, upper data bits carrying noise at the moment of the read, and a transmitter that withholds ready for several cycles. The bench models the converter with a one-cycle interrupt pulse and puts deliberately dirty words on the bus, with the upper bits set both during and between reads. It also stalls ready on every third byte, so that the hold rule, the gap count and the period timing are all exercised while backpressure stretches the drain phase.

// File: rtl/adc_readout_seq.sv
module adc_readout_seq #(
  parameter int CH_COUNT   = 4,
  parameter int VALID_W    = 14,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 100000,
  parameter int PERIOD_CYC = 10000000,
  parameter logic [3:0] MODE_WORD = 4'b0011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_in,
  output logic [15:0] bus_out,
  output logic        bus_oe,
  output logic        wr_n,
  output logic        rd_n,
  output logic        convst_n,
  input  logic        int_n,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready
);
  localparam int SW = $clog2(STROBE_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int PW = $clog2(PERIOD_CYC + 1);
  localparam int CW = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1;
  localparam logic [15:0] KEEP = 16'((32'd1 << VALID_W) - 1);

  typedef enum logic [3:0] {
    S_CSET, S_CWR, S_CHOLD, S_IDLE, S_START, S_WAIT,
    S_READ, S_HI, S_GAP_HI, S_LO, S_GAP_LO
  } st_t;

  st_t           st;
  logic [SW-1:0] scnt;
  logic [GW-1:0] gcnt;
  logic [PW-1:0] pcnt;
  logic [CW-1:0] ch;
  logic [15:0]   res;
  logic          int_meta, int_sync, int_prev, int_seen;
  logic          int_fall;

  assign int_fall = int_prev & ~int_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_meta <= 1'b1;
      int_sync <= 1'b1;
      int_prev <= 1'b1;
    end else begin
      int_meta <= int_n;
      int_sync <= int_meta;
      int_prev <= int_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CSET;
      scnt     <= '0;
      gcnt     <= '0;
      pcnt     <= '0;
      ch       <= '0;
      res      <= '0;
      int_seen <= 1'b0;
    end else begin
      if (pcnt != PW'(PERIOD_CYC - 1)) pcnt <= pcnt + 1'b1;
      if (int_fall && (st == S_START || st == S_WAIT)) int_seen <= 1'b1;
      case (st)
        S_CSET: begin
          st   <= S_CWR;
          scnt <= '0;
        end
        S_CWR:
          if (scnt == SW'(STROBE_CYC - 1)) st <= S_CHOLD;
          else scnt <= scnt + 1'b1;
        S_CHOLD: begin
          st   <= S_IDLE;
          pcnt <= PW'(PERIOD_CYC - 1);
        end
        S_IDLE:
          if (pcnt == PW'(PERIOD_CYC - 1)) begin
            st       <= S_START;
            scnt     <= '0;
            pcnt     <= '0;
            int_seen <= 1'b0;
          end
        S_START:
          if (scnt == SW'(STROBE_CYC - 1)) st <= S_WAIT;
          else scnt <= scnt + 1'b1;
        S_WAIT:
          if (int_seen) begin
            st   <= S_READ;
            scnt <= '0;
            ch   <= '0;
          end
        S_READ:
          if (scnt == SW'(STROBE_CYC - 1)) begin
            res <= bus_in & KEEP;
            st  <= S_HI;
          end else scnt <= scnt + 1'b1;
        S_HI:
          if (tx_ready) begin
            st   <= S_GAP_HI;
            gcnt <= '0;
          end
        S_GAP_HI:
          if (gcnt == GW'(GAP_CYC - 1)) st <= S_LO;
          else gcnt <= gcnt + 1'b1;
        S_LO:
          if (tx_ready) begin
            st   <= S_GAP_LO;
            gcnt <= '0;
          end
        S_GAP_LO:
          if (gcnt == GW'(GAP_CYC - 1)) begin
            if (ch == CW'(CH_COUNT - 1)) st <= S_IDLE;
            else begin
              ch   <= ch + 1'b1;
              scnt <= '0;
              st   <= S_READ;
            end
          end else gcnt <= gcnt + 1'b1;
        default: st <= S_CSET;
      endcase
    end
  end

  assign bus_oe   = (st == S_CSET) || (st == S_CWR) || (st == S_CHOLD);
  assign bus_out  = {12'h000, MODE_WORD};
  assign wr_n     = (st != S_CWR);
  assign convst_n = (st != S_START);
  assign rd_n     = (st != S_READ);
  assign tx_valid = (st == S_HI) || (st == S_LO);
  assign tx_data  = (st == S_HI) ? res[15:8] : res[7:0];

  a_r1_cfg_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (bus_oe && bus_out[3:0] == MODE_WORD));
  a_r2_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!convst_n && !rd_n));
  a_r4_read_after_int: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> int_seen);
  a_r6_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && st == S_HI) |-> ((tx_data & ~KEEP[15:8]) == 8'h00));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  a_r8_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);
endmodule

// File: tb/adc_readout_seq_tb.sv
`timescale 1ns/1ps
module adc_readout_seq_tb;
  localparam int STB = 2;
  localparam int GAP = 5;
  localparam int PER = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_in = 16'h0000;
  logic [15:0] bus_out;
  logic bus_oe, wr_n, rd_n, convst_n;
  logic int_n = 1'b1;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b1;

  always #2.5 clk = ~clk;

  adc_readout_seq #(.CH_COUNT(4), .VALID_W(14), .STROBE_CYC(STB),
                    .GAP_CYC(GAP), .PERIOD_CYC(PER), .MODE_WORD(4'b0011)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .wr_n(wr_n), .rd_n(rd_n), .convst_n(convst_n), .int_n(int_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));

  localparam logic [15:0] VEC [12] = '{
    16'hC123, 16'h3FFF, 16'h4000, 16'h8ABC,
    16'h0001, 16'hFFFF, 16'h2AAA, 16'hD555,
    16'h1234, 16'hE000, 16'h7F80, 16'h00FF};

  int nchk = 0, nfail = 0;
  int cyc = 0, wr_len = 0, cv_len = 0, rd_len = 0, wr_count = 0;
  int last_fall = 0, conv_count = 0, int_delay = 0, idx = 0;
  int byte_cnt = 0, low_cnt = 0, stall = 0, oe_bad = 0;
  bit cfg_bad = 0, int_pulsed = 0, hold_pend = 0;
  bit prev_wr = 1, prev_cv = 1, prev_rd = 1, prev_valid = 0;
  logic [7:0] hold_data = 8'h00;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!wr_n) begin
      wr_len++;
      if (!bus_oe || bus_out != 16'h0003) cfg_bad = 1;
    end
    if (!prev_wr && wr_n) begin
      wr_count++;
      chk(wr_len == STB, "R1", "write strobe length", wr_len, STB);
      chk(!cfg_bad, "R1", "mode word driven", int'(bus_out), 3);
      wr_len = 0;
    end
    if (conv_count > 0 && bus_oe) oe_bad++;

    if (!convst_n) cv_len++;
    if (prev_cv && !convst_n) begin
      if (conv_count > 0) chk(cyc - last_fall == PER, "R9", "conversion spacing", cyc - last_fall, PER);
      else chk(wr_count == 1, "R9", "first start after config", wr_count, 1);
      last_fall = cyc;
      conv_count++;
      int_pulsed = 0;
    end
    if (!prev_cv && convst_n) begin
      chk(cv_len == STB, "R3", "convert-start length", cv_len, STB);
      cv_len = 0;
      int_delay = 7;
    end
    if (int_delay > 0) begin
      int_delay--;
      if (int_delay == 0) begin
        int_n = 1'b0;
        int_pulsed = 1;
      end
    end else int_n = 1'b1;

    if (prev_rd && !rd_n)
      chk(int_pulsed, "R4", "read issued only after interrupt", int'(int_pulsed), 1);
    if (!rd_n) begin
      rd_len++;
      bus_in = VEC[idx % 12];
    end else bus_in = {cyc[7:0], cyc[7:0]} ^ 16'hC3C3;
    if (!prev_rd && rd_n) begin
      chk(rd_len == STB, "R5", "read strobe length", rd_len, STB);
      rd_len = 0;
      idx++;
    end

    if (hold_pend) begin
      chk(tx_valid && tx_data == hold_data, "R7", "byte held under backpressure", int'(tx_data), int'(hold_data));
      hold_pend = 0;
    end
    if (tx_valid && !prev_valid && byte_cnt > 0)
      chk(low_cnt >= GAP, "R8", "idle gap between bytes", low_cnt, GAP);
    if (tx_valid) low_cnt = 0; else low_cnt++;

    if (tx_valid) begin
      tx_ready = !((byte_cnt % 3 == 1) && stall < 3);
      if (!tx_ready) stall++;
    end else begin
      stall = 0;
      tx_ready = 1'b1;
    end

    if (tx_valid && tx_ready) begin
      logic [15:0] v;
      logic [7:0] e;
      v = VEC[(byte_cnt / 2) % 12];
      if (byte_cnt % 2 == 0) begin
        e = v[15:8] & 8'h3F;
        chk(tx_data == e, "R6", "masked high byte", int'(tx_data), int'(e));
      end else begin
        e = v[7:0];
        chk(tx_data == e, "R7", "low byte follows high", int'(tx_data), int'(e));
      end
      byte_cnt++;
    end else if (tx_valid && !tx_ready) begin
      hold_pend = 1;
      hold_data = tx_data;
    end

    prev_wr = wr_n;
    prev_cv = convst_n;
    prev_rd = rd_n;
    prev_valid = tx_valid;
  end

  initial begin
    int wd;
    wd = 0;
    repeat (3) @(negedge clk);
    chk(bus_oe == 1'b1, "R1", "reset bus_oe", int'(bus_oe), 1);
    chk(wr_n && rd_n && convst_n, "R1", "reset strobes idle", int'({wr_n, rd_n, convst_n}), 7);
    chk(tx_valid == 1'b0, "R1", "reset tx_valid", int'(tx_valid), 0);
    rst_n = 1'b1;
    while (conv_count < 4 && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 20000) chk(0, "WD", "watchdog expired", wd, 20000);
    chk(byte_cnt == 24, "R7", "eight bytes per conversion", byte_cnt, 24);
    chk(idx == 12, "R5", "four reads per conversion", idx, 12);
    chk(wr_count == 1, "R2", "single mode write", wr_count, 1);
    chk(oe_bad == 0, "R2", "bus released after config", oe_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule